// File: doc/BRIEF.md
# Memory field extension controller

This block widens the 4K-word address space of a 12-bit processor by one field bit, so that two memory fields can be reached. It keeps four pieces of field state: an instruction field, a buffer that holds a pending instruction field, a data field, and a two-bit save register used across interrupts. It decodes the processor's I/O transfer words that change, read and restore these fields. For the read words it drives the bits to be merged into the accumulator.

A program's change of instruction field is not applied at once. The new value waits in the buffer and moves into the instruction field at the next JMP or JMS. From the buffering word until that jump, the processor's interrupt-enable level is held low, so that no interrupt can land between the two. On interrupt entry both fields are saved and then cleared, so the service routine runs in field 0. A restore word then puts the saved fields back: the data field at once, and the instruction field through the buffer at the returning jump. A manual load strobe from the panel switches overrides everything else.

Bits of the 12-bit word are numbered 0 (most significant) to 11. Word bit k is vector index 11-k on `instr`, `ac_or` and `ac_clr`.

Top module: `mfx_ctrl`

## Requirements
- R1: After reset `inst_field`, `inst_buf` and `data_field` read 0, the saved fields read 0 through the save-read word, and `int_ok` follows `cpu_int_ok`.
- R2: A valid word with bits 0-2 = 6, bits 3-5 = 2, bits 9-11 = 1 (octal 62N1) and bits 6-7 = 0 loads bit 8 into `data_field` on the next edge. With bits 6-7 not both 0 the word has no effect.
- R3: Octal 62N2 with bits 6-7 = 0 loads bit 8 into `inst_buf` only. `inst_field` is unchanged, and an interrupt inhibit is set.
- R4: A `jmp_exec` pulse copies `inst_buf` into `inst_field` on the next edge and clears the inhibit.
- R5: `int_ok` is `cpu_int_ok` while the inhibit is clear, and 0 while it is set.
- R6: Octal 6214 (data field read) and octal 6224 (instruction field read) assert `ac_load` in the same cycle. They drive the selected field on word bit 8 of `ac_or` (index 3) and set `ac_clr` for word bits 6 and 7 (indices 5 and 4). All other bits of both vectors are 0.
- R7: Octal 6234 asserts `ac_load`. It drives save bit 0 (the saved instruction field) on word bit 8 (index 3) and save bit 1 (the saved data field) on word bit 11 (index 0), with `ac_clr` all 0.
- R8: An `int_entry` pulse stores the instruction field into save bit 0 and the data field into save bit 1. It clears `inst_field`, `inst_buf`, `data_field` and the inhibit.
- R9: Octal 6244 loads save bit 0 into `inst_buf` and save bit 1 into `data_field`. `inst_field` is unchanged until the next jump.
- R10: `panel_load` writes `sw_if` into `inst_field` and `inst_buf`, writes `sw_df` into `data_field` and clears the inhibit. It takes priority over a same-cycle interrupt entry, field word or jump.
- R11: Words that are not valid, whose bits 0-5 differ from octal 62, or that carry an undefined code change no state. In every cycle with no read word, `ac_load`, `ac_or` and `ac_clr` are 0.
- R12: `int_entry` takes priority over a field word and a jump in the same cycle: the saved values are the fields from before the edge, and all fields end up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | `instr` holds an I/O transfer word being executed this cycle |
| instr | input | 12 | Instruction word, word bit 0 at index 11 |
| jmp_exec | input | 1 | A JMP or JMS executes this cycle |
| int_entry | input | 1 | The processor enters an interrupt this cycle |
| panel_load | input | 1 | Manual load-address strobe |
| sw_if | input | 1 | Instruction field switch |
| sw_df | input | 1 | Data field switch |
| cpu_int_ok | input | 1 | Processor interrupt-enable level before gating |
| inst_field | output | 1 | Current instruction field |
| inst_buf | output | 1 | Pending instruction field |
| data_field | output | 1 | Current data field |
| int_ok | output | 1 | Gated interrupt-enable level |
| ac_load | output | 1 | Accumulator merge request for a read word |
| ac_or | output | 12 | Bits to set in the accumulator |
| ac_clr | output | 12 | Bits to clear in the accumulator |

## Verification
The hardest case to reach is a return from an interrupt whose saved fields differ from each other. The saved instruction field only reaches `inst_field` through the buffer and a later jump, while the data field moves at once. The stimulus first sets field 1 in both registers, enters an interrupt, and reads back the saved pair. It then changes fields inside the service routine, restores, and checks the two fields part by part before and after the returning jump. Same-cycle collisions of panel load, interrupt entry, field words and jumps are driven on purpose to check the priority order.

// File: rtl/mfx_pkg.sv
package mfx_pkg;
  localparam int WORD_W  = 12;
  localparam int SAVE_W  = 2;
  localparam int GRP_W   = 3;
  // vector index of word bit k is WORD_W-1-k
  localparam int AC_B6   = WORD_W - 1 - 6;
  localparam int AC_B7   = WORD_W - 1 - 7;
  localparam int AC_B8   = WORD_W - 1 - 8;
  localparam int AC_B11  = WORD_W - 1 - 11;
  localparam logic [GRP_W-1:0] OPC_IOT  = 3'o6;
  localparam logic [GRP_W-1:0] DEV_FLD  = 3'o2;
  localparam logic [GRP_W-1:0] PUL_CDF  = 3'o1;
  localparam logic [GRP_W-1:0] PUL_CIF  = 3'o2;
  localparam logic [GRP_W-1:0] PUL_GRP4 = 3'o4;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_DF,
    OP_SET_IB,
    OP_RD_DF,
    OP_RD_IF,
    OP_RD_SAVE,
    OP_RESTORE
  } fld_op_e;
endpackage

// File: rtl/mfx_rst_sync.sv
module mfx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/mfx_decode.sv
module mfx_decode
  import mfx_pkg::*;
(
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr,
  output fld_op_e           op,
  output logic              fld_n
);
  logic [GRP_W-1:0] g_opc, g_dev, g_fld, g_pul;

  assign g_opc = instr[11:9];
  assign g_dev = instr[8:6];
  assign g_fld = instr[5:3];
  assign g_pul = instr[2:0];
  assign fld_n = g_fld[0];

  always_comb begin
    op = OP_NONE;
    if (instr_valid && g_opc == OPC_IOT && g_dev == DEV_FLD) begin
      if (g_pul == PUL_CDF && g_fld[2:1] == 2'b00) begin
        op = OP_SET_DF;
      end else if (g_pul == PUL_CIF && g_fld[2:1] == 2'b00) begin
        op = OP_SET_IB;
      end else if (g_pul == PUL_GRP4) begin
        case (g_fld)
          3'o1:    op = OP_RD_DF;
          3'o2:    op = OP_RD_IF;
          3'o3:    op = OP_RD_SAVE;
          3'o4:    op = OP_RESTORE;
          default: op = OP_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mfx_fields.sv
module mfx_fields
  import mfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst_n,
  input  fld_op_e           op,
  input  logic              fld_n,
  input  logic              jmp_exec,
  input  logic              int_entry,
  input  logic              panel_load,
  input  logic              sw_if,
  input  logic              sw_df,
  input  logic              cpu_int_ok,
  output logic              if_q,
  output logic              ib_q,
  output logic              df_q,
  output logic [SAVE_W-1:0] sf_q,
  output logic              int_ok
);
  logic              if_d, ib_d, df_d, inh_d, inh_q;
  logic [SAVE_W-1:0] sf_d;
  logic              upd_en;

  always_comb begin
    if_d  = if_q;
    ib_d  = ib_q;
    df_d  = df_q;
    sf_d  = sf_q;
    inh_d = inh_q;
    if (panel_load) begin
      if_d  = sw_if;
      ib_d  = sw_if;
      df_d  = sw_df;
      inh_d = 1'b0;
    end else if (int_entry) begin
      sf_d  = {df_q, if_q};
      if_d  = 1'b0;
      ib_d  = 1'b0;
      df_d  = 1'b0;
      inh_d = 1'b0;
    end else begin
      if (jmp_exec) begin
        if_d  = ib_q;
        inh_d = 1'b0;
      end
      case (op)
        OP_SET_DF:  df_d = fld_n;
        OP_SET_IB: begin
          ib_d  = fld_n;
          inh_d = 1'b1;
        end
        OP_RESTORE: begin
          ib_d = sf_q[0];
          df_d = sf_q[1];
        end
        default: ;
      endcase
    end
  end

  assign upd_en = panel_load | int_entry | jmp_exec | (op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_q <= 1'b0; ib_q <= 1'b0; df_q <= 1'b0; sf_q <= '0; inh_q <= 1'b0;
    end else if (!srst_n) begin
      if_q <= 1'b0; ib_q <= 1'b0; df_q <= 1'b0; sf_q <= '0; inh_q <= 1'b0;
    end else if (upd_en) begin
      if_q <= if_d; ib_q <= ib_d; df_q <= df_d; sf_q <= sf_d; inh_q <= inh_d;
    end
  end

  assign int_ok = cpu_int_ok & ~inh_q;
endmodule

// File: rtl/mfx_acread.sv
module mfx_acread
  import mfx_pkg::*;
(
  input  fld_op_e           op,
  input  logic              if_q,
  input  logic              df_q,
  input  logic [SAVE_W-1:0] sf_q,
  output logic              ac_load,
  output logic [WORD_W-1:0] ac_or,
  output logic [WORD_W-1:0] ac_clr
);
  always_comb begin
    ac_load = 1'b0;
    ac_or   = '0;
    ac_clr  = '0;
    case (op)
      OP_RD_DF, OP_RD_IF: begin
        ac_load       = 1'b1;
        ac_or[AC_B8]  = (op == OP_RD_DF) ? df_q : if_q;
        ac_clr[AC_B6] = 1'b1;
        ac_clr[AC_B7] = 1'b1;
      end
      OP_RD_SAVE: begin
        ac_load       = 1'b1;
        ac_or[AC_B8]  = sf_q[0];
        ac_or[AC_B11] = sf_q[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mfx_ctrl.sv
module mfx_ctrl
  import mfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr,
  input  logic              jmp_exec,
  input  logic              int_entry,
  input  logic              panel_load,
  input  logic              sw_if,
  input  logic              sw_df,
  input  logic              cpu_int_ok,
  output logic              inst_field,
  output logic              inst_buf,
  output logic              data_field,
  output logic              int_ok,
  output logic              ac_load,
  output logic [WORD_W-1:0] ac_or,
  output logic [WORD_W-1:0] ac_clr
);
  logic              srst_n;
  fld_op_e           op;
  logic              fld_n;
  logic [SAVE_W-1:0] sf_q;

  mfx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  mfx_decode u_dec (
    .instr_valid(instr_valid), .instr(instr), .op(op), .fld_n(fld_n)
  );

  mfx_fields u_fld (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .op(op), .fld_n(fld_n),
    .jmp_exec(jmp_exec), .int_entry(int_entry), .panel_load(panel_load),
    .sw_if(sw_if), .sw_df(sw_df), .cpu_int_ok(cpu_int_ok),
    .if_q(inst_field), .ib_q(inst_buf), .df_q(data_field), .sf_q(sf_q),
    .int_ok(int_ok)
  );

  mfx_acread u_rd (
    .op(op), .if_q(inst_field), .df_q(data_field), .sf_q(sf_q),
    .ac_load(ac_load), .ac_or(ac_or), .ac_clr(ac_clr)
  );
endmodule

// File: rtl/mfx_chk.sv
module mfx_chk (
  input logic        clk,
  input logic        srst_n,
  input logic        instr_valid,
  input logic [11:0] instr,
  input logic        jmp_exec,
  input logic        int_entry,
  input logic        panel_load,
  input logic        sw_if,
  input logic        sw_df,
  input logic        inst_field,
  input logic        inst_buf,
  input logic        data_field,
  input logic        int_ok,
  input logic        ac_load,
  input logic [11:0] ac_or
);
  logic fld_grp, w_cdf, w_cif, w_read, quiet;

  assign fld_grp = instr_valid && (instr[11:6] == 6'o62);
  assign w_cdf   = fld_grp && (instr[2:0] == 3'o1) && (instr[5:4] == 2'b00);
  assign w_cif   = fld_grp && (instr[2:0] == 3'o2) && (instr[5:4] == 2'b00);
  assign w_read  = fld_grp && (instr[2:0] == 3'o4) &&
                   (instr[5:3] == 3'o1 || instr[5:3] == 3'o2 || instr[5:3] == 3'o3);
  assign quiet   = !panel_load && !int_entry;

  // R2
  cdf_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (w_cdf && quiet) |=> (data_field == $past(instr[3])));

  // R3
  cif_hold_if_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (w_cif && quiet && !jmp_exec) |=> (inst_buf == $past(instr[3])) && $stable(inst_field));

  // R5
  cif_inhibit_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (w_cif && quiet && !jmp_exec) |=> !int_ok);

  // R4
  jmp_commit_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (jmp_exec && quiet && !w_cif) |=> (inst_field == $past(inst_buf)));

  // R8
  int_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (int_entry && !panel_load) |=> (!inst_field && !inst_buf && !data_field));

  // R10
  panel_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    panel_load |=> (inst_field == $past(sw_if)) && (inst_buf == $past(sw_if)) &&
                   (data_field == $past(sw_df)));

  // R11
  no_read_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !w_read |-> (!ac_load && ac_or == 12'd0));
endmodule

bind mfx_ctrl mfx_chk u_chk (
  .clk(clk), .srst_n(srst_n), .instr_valid(instr_valid), .instr(instr),
  .jmp_exec(jmp_exec), .int_entry(int_entry), .panel_load(panel_load),
  .sw_if(sw_if), .sw_df(sw_df), .inst_field(inst_field), .inst_buf(inst_buf),
  .data_field(data_field), .int_ok(int_ok), .ac_load(ac_load), .ac_or(ac_or)
);

// File: tb/test_mfx_ctrl.sv
module test_mfx_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid, jmp_exec, int_entry, panel_load, sw_if, sw_df, cpu_int_ok;
  logic [11:0] instr;
  logic        inst_field, inst_buf, data_field, int_ok, ac_load;
  logic [11:0] ac_or, ac_clr;

  int checks = 0;
  int failures = 0;

  typedef struct packed {
    logic [7:0]  req;
    logic        ld;
    logic [11:0] orv;
    logic [11:0] clr;
    logic        iok;
    logic        fi;
    logic        fb;
    logic        fd;
  } sb_item_t;

  sb_item_t sb_q[$];

  // bench model of the field state
  logic m_if = 1'b0, m_ib = 1'b0, m_df = 1'b0, m_inh = 1'b0;
  logic [1:0] m_sf = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfx_ctrl i_mfx_ctrl (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .jmp_exec(jmp_exec), .int_entry(int_entry), .panel_load(panel_load),
    .sw_if(sw_if), .sw_df(sw_df), .cpu_int_ok(cpu_int_ok),
    .inst_field(inst_field), .inst_buf(inst_buf), .data_field(data_field),
    .int_ok(int_ok), .ac_load(ac_load), .ac_or(ac_or), .ac_clr(ac_clr)
  );

  task automatic chk(input int req, input string what, input logic [11:0] act,
                     input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; expected results come from the requirement text
  task automatic step(input int req, input logic v, input logic [11:0] w,
                      input logic j, input logic ie, input logic pl,
                      input logic si, input logic sd, input logic ok);
    sb_item_t it;
    logic grp, cdf, cif, rdf, rif, rib, rmf;
    @(negedge clk);
    instr_valid = v; instr = w; jmp_exec = j; int_entry = ie;
    panel_load = pl; sw_if = si; sw_df = sd; cpu_int_ok = ok;
    grp = v && (w[11:6] == 6'o62);
    cdf = grp && w[2:0] == 3'o1 && w[5:4] == 2'b00;   // R2
    cif = grp && w[2:0] == 3'o2 && w[5:4] == 2'b00;   // R3
    rdf = grp && w[2:0] == 3'o4 && w[5:3] == 3'o1;    // R6
    rif = grp && w[2:0] == 3'o4 && w[5:3] == 3'o2;    // R6
    rib = grp && w[2:0] == 3'o4 && w[5:3] == 3'o3;    // R7
    rmf = grp && w[2:0] == 3'o4 && w[5:3] == 3'o4;    // R9
    it = '0;
    it.req = req[7:0];
    it.iok = ok & ~m_inh;                              // R5
    if (rdf || rif) begin
      it.ld = 1'b1;
      it.orv[3] = rdf ? m_df : m_if;
      it.clr[5] = 1'b1;
      it.clr[4] = 1'b1;
    end else if (rib) begin
      it.ld = 1'b1;
      it.orv[3] = m_sf[0];
      it.orv[0] = m_sf[1];
    end
    if (pl) begin                                      // R10
      m_if = si; m_ib = si; m_df = sd; m_inh = 1'b0;
    end else if (ie) begin                             // R8, R12
      m_sf = {m_df, m_if}; m_if = 1'b0; m_ib = 1'b0; m_df = 1'b0; m_inh = 1'b0;
    end else begin
      if (j) begin m_if = m_ib; m_inh = 1'b0; end      // R4
      if (cdf) m_df = w[3];
      if (cif) begin m_ib = w[3]; m_inh = 1'b1; end
      if (rmf) begin m_ib = m_sf[0]; m_df = m_sf[1]; end
    end
    it.fi = m_if; it.fb = m_ib; it.fd = m_df;
    sb_q.push_back(it);
  endtask

  task automatic iot(input int req, input logic [11:0] w);
    step(req, 1'b1, w, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic idle(input int req);
    step(req, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  // monitor: combinational outputs before the edge, registers after it
  initial begin
    sb_item_t it;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() != 0) begin
        it = sb_q[0];
        chk(int'(it.req), "ac_load", {11'd0, ac_load}, {11'd0, it.ld});
        chk(int'(it.req), "ac_or",   ac_or,  it.orv);
        chk(int'(it.req), "ac_clr",  ac_clr, it.clr);
        chk(int'(it.req), "int_ok",  {11'd0, int_ok}, {11'd0, it.iok});
        @(posedge clk);
        #1;
        chk(int'(it.req), "inst_field", {11'd0, inst_field}, {11'd0, it.fi});
        chk(int'(it.req), "inst_buf",   {11'd0, inst_buf},   {11'd0, it.fb});
        chk(int'(it.req), "data_field", {11'd0, data_field}, {11'd0, it.fd});
        void'(sb_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    instr_valid = 1'b0; instr = '0; jmp_exec = 1'b0; int_entry = 1'b0;
    panel_load = 1'b0; sw_if = 1'b0; sw_df = 1'b0; cpu_int_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, save register reads 0
    idle(1);
    iot(1, 12'o6234);
    // R6 data field read at 0
    iot(6, 12'o6214);
    // R2 change data field to 1, then read it
    iot(2, 12'o6211);
    iot(6, 12'o6214);
    // R2 bits 6-7 nonzero: ignored
    iot(2, 12'o6201 | 12'o0020);
    iot(2, 12'o6241);
    // R11 other opcode, other device, undefined code, not valid
    iot(11, 12'o7201);
    iot(11, 12'o6301);
    iot(11, 12'o6254);
    step(11, 1'b0, 12'o6202, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R3 change instruction field to 1; IF stays 0, inhibit set
    iot(3, 12'o6212);
    // R5 interrupt level held low while pending; RIF still reads 0
    idle(5);
    iot(6, 12'o6224);
    // R4 jump commits the buffer
    step(4, 1'b0, 12'o0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(5);
    iot(6, 12'o6224);
    // R5 processor level low passes through
    step(5, 1'b0, 12'o0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R8 interrupt entry with IF=1 DF=1
    step(8, 1'b0, 12'o0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    iot(7, 12'o6234);
    // service routine changes data field, then R9 restore
    iot(2, 12'o6201);
    iot(9, 12'o6244);
    idle(9);
    step(4, 1'b0, 12'o0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // differing saved fields: IF=0 DF=1
    iot(3, 12'o6202);
    step(4, 1'b0, 12'o0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step(8, 1'b0, 12'o0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    iot(7, 12'o6234);
    iot(9, 12'o6244);
    step(4, 1'b0, 12'o0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R10 panel load wins over a same-cycle data field change and jump
    iot(3, 12'o6212);
    step(10, 1'b1, 12'o6201, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    idle(10);
    step(10, 1'b1, 12'o6211, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    // R12 interrupt entry beats a same-cycle field word and jump
    iot(2, 12'o6211);
    iot(3, 12'o6202);
    step(12, 1'b1, 12'o6201, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    iot(12, 12'o6234);
    idle(12);

    @(negedge clk);
    instr_valid = 1'b0; jmp_exec = 1'b0; int_entry = 1'b0; panel_load = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule